// File: doc/BRIEF.md
# Quarter-Wave Cosine Oscillator

This block is a numerically controlled cosine oscillator. On every clock a frequency control word is added into a phase accumulator that wraps around. The upper part of the accumulated phase picks one of 1024 points on a cosine cycle. The block stores only the first quarter of the wave in a table. It rebuilds the other three quarters by mirroring the table address and by inverting the sign of the table output.

The output is an 8-bit signed sample. Changing the control word produces a new frequency, and the change reaches the output two clocks later. With a 100 MHz clock one step of the control word is about 381.47 Hz (100e6 / 2^18). The 8-bit amplitude gives an error against an ideal cosine of roughly ±0.009 of full scale and a spurious-free range near 64 dB.

Top module: `nco_quarter_cos`

## Requirements
- R1: A synchronous reset, active high, clears the accumulator and both pipeline stages. The sample reads 0 after any clock edge taken in reset. The first edge after reset produces 127, because the phase is then 0.
- R2: On each clock edge outside reset the accumulator takes its old value plus the control word, modulo 2^18. A word of 2^18 − 2^16 therefore steps the phase backwards by a quarter cycle.
- R3: Only accumulator bits 17:8 form the phase. Bits 7:0 never reach the output, so with a control word of 1 the sample stays at 127 for the first 256 edges after reset.
- R4: Accumulator bits 17:16 name the quadrant. Bits 15:8 address the quarter table, and when bit 16 is 1 the address is bit-inverted (255 − address).
- R5: When bit 17 XOR bit 16 is 1, the output is the bitwise inverse of the zero-extended table value (−v−1). Otherwise it is +v. At phases 0, 256, 512 and 768 the samples are 127, −1, −128 and 0.
- R6: Table entry k, for k from 0 to 255, holds round(127·cos(π/2·(k+0.5)/256)). Entry 0 is 127 and entry 255 is 0.
- R7: A control word present at clock edge n is in the accumulator after edge n. Its effect shows in the sample after edge n+1, which is a two-clock latency.
- R8: While the control word is 0 the accumulator holds its value. The sample stays unchanged from the second edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw | input | 18 | Frequency control word added to the phase every clock |
| sample | output | 8 | Signed cosine sample |

## Verification
The hardest cases to reach are the exact quadrant edges and the last table entries. Only these cases show whether the address inversion and the output inversion line up, and a slow control word visits them only after hundreds of thousands of clocks. The stimulus reaches the four quadrant edges directly with a control word of 2^16. It then sweeps every one of the 1024 phase points with a word of 256. Backward and wrapping steps, words that change on every cycle, and a reset in the middle of a run cover the latency and the reset behaviour.

// File: rtl/nco_quarter_cos.sv
module nco_quarter_cos #(
  parameter int PHASE_W = 18,
  parameter int LUT_PHASE_W = 10,
  parameter int AMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PHASE_W-1:0]       fcw,
  output logic signed [AMP_W-1:0]  sample
);
  localparam int QADDR_W = LUT_PHASE_W - 2;
  localparam int DEPTH   = 1 << QADDR_W;
  localparam int MAG_W   = AMP_W - 1;
  localparam int PEAK    = (1 << MAG_W) - 1;

  logic [PHASE_W-1:0] acc;
  logic [MAG_W-1:0]   mag_q;
  logic               neg_q;

  wire [LUT_PHASE_W-1:0] phase = acc[PHASE_W-1 -: LUT_PHASE_W];
  wire [1:0]             quad  = phase[LUT_PHASE_W-1 -: 2];
  wire [QADDR_W-1:0]     raw   = phase[QADDR_W-1:0];
  wire [QADDR_W-1:0]     addr  = quad[0] ? ~raw : raw;

  // quarter-wave cosine table, sampled at half-step offsets
  logic [MAG_W-1:0] lut [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_lut
    localparam real ANG = 1.5707963267948966 * (real'(k) + 0.5) / real'(DEPTH);
    localparam int  VAL = $rtoi($floor(real'(PEAK) * $cos(ANG) + 0.5));
    assign lut[k] = MAG_W'(VAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      mag_q <= '0;
      neg_q <= 1'b0;
    end else begin
      acc   <= acc + fcw;
      mag_q <= lut[addr];
      neg_q <= quad[1] ^ quad[0];
    end
  end

  assign sample = neg_q ? ~{1'b0, mag_q} : {1'b0, mag_q};

  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> sample == '0);

  assert_sign_follows_quadrant_R5: assert property (@(posedge clk) disable iff (rst)
    live != 2'd0 |-> sample[AMP_W-1] == ($past(quad[1]) ^ $past(quad[0])));

  assert_quadrant_edge_peak_R4: assert property (@(posedge clk) disable iff (rst)
    (live != 2'd0 && $past(raw) == '0 && !$past(quad[0]))
      |-> (sample == AMP_W'(PEAK) || sample == AMP_W'(-PEAK - 1)));

  assert_hold_on_zero_word_R8: assert property (@(posedge clk) disable iff (rst)
    (live >= 2'd2 && $past(fcw, 2) == '0) |-> $stable(sample));
endmodule

// File: tb/nco_quarter_cos_tb.sv
module nco_quarter_cos_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [17:0] fcw = '0;
  logic signed [7:0] sample;

  nco_quarter_cos u_dut (.clk(clk), .rst(rst), .fcw(fcw), .sample(sample));

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int model_acc = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];

  function automatic int cos_of(int a);
    int p, q, ad, m;
    p = (a >> 8) & 1023;
    q = p >> 8;
    ad = p & 255;
    if ((q & 1) != 0) ad = 255 - ad;
    m = $rtoi($floor(127.0 * $cos(1.5707963267948966 * (real'(ad) + 0.5) / 256.0) + 0.5));
    if (((q ^ (q >> 1)) & 1) != 0) return -m - 1;
    return m;
  endfunction

  task automatic step(input int word, input bit r, input string tag);
    @(negedge clk);
    rst = r;
    fcw = word[17:0];
    @(posedge clk);
    if (r) begin
      exp_q.push_back(0);
      model_acc = 0;
    end else begin
      exp_q.push_back(cos_of(model_acc));
      model_acc = (model_acc + word) & 32'h3FFFF;
    end
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (int'(sample) != e) begin
        mismatched++;
        $display("FAIL %s: sample=%0d expected=%0d", t, int'(sample), e);
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: held in reset
    for (int i = 0; i < 3; i++) step(0, 1'b1, "R1");
    // R1 and R8: first edges after reset with a zero word
    for (int i = 0; i < 4; i++) step(0, 1'b0, "R8");
    // R3: low accumulator bits do not reach the output
    for (int i = 0; i < 300; i++) step(1, 1'b0, "R3");
    // R4/R5: quadrant edges 127, -1, -128, 0
    step(0, 1'b1, "R1");
    for (int i = 0; i < 9; i++) step(65536, 1'b0, "R5");
    // R6: every table point
    step(0, 1'b1, "R1");
    for (int i = 0; i < 1030; i++) step(256, 1'b0, "R6");
    // R2: backward quarter steps and wrap
    for (int i = 0; i < 10; i++) step(262144 - 65536, 1'b0, "R2");
    for (int i = 0; i < 200; i++) step(3 * 65536 + 12345, 1'b0, "R2");
    // R4: odd quadrants, folded address
    for (int i = 0; i < 200; i++) step(65536 + 768, 1'b0, "R4");
    // R7: word changes every cycle
    for (int i = 0; i < 60; i++) step((i * 40503 + 977) & 32'h3FFFF, 1'b0, "R7");
    // R1: reset in mid-run
    step(5000, 1'b1, "R1");
    step(5000, 1'b1, "R1");
    for (int i = 0; i < 20; i++) step(9000, 1'b0, "R1");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule